// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is an 8-bit control and status register for a small microcontroller core. It holds one run enable for each of two timers and latches their overflow events. It also watches two active-low external interrupt pins and raises a request for each of them. Each pin has a mode bit. In edge mode the pin's flag latches on a falling edge. In level mode the request follows the pin and stays up for as long as the pin is low.

Software reaches the register in two ways. A byte port at the register address reads or writes all eight bits at once. A single-bit port works at eight consecutive bit addresses that begin at the register address. Hardware events set the flags. A flag is cleared by a software write, or by an acknowledge strobe from the interrupt controller when that interrupt is serviced. The pins pass through a synchronizer before any detection takes place.

Top module: `tmr_irq_ctl`

## Requirements
- R1: After reset every register bit reads 0. Both timers are stopped, both pins are in level mode, and no flag is pending.
- R2: A byte write at address 0x88 loads all eight bits. The bit layout, from bit 7 down to bit 0, is: timer 1 flag, timer 1 run, timer 0 flag, timer 0 run, external 1 flag, external 1 mode, external 0 flag, external 0 mode. A byte write to any other address changes nothing.
- R3: A bit write at address 0x88+n changes only bit n. The other seven bits keep their values.
- R4: A byte read at 0x88 returns the register. A bit read at 0x88+n returns bit n. Reads at any other address return 0.
- R5: A one-cycle overflow pulse from timer i sets that timer's flag at the next clock edge. The flag then stays set.
- R6: A timer flag is cleared by its acknowledge strobe, or by a software write of 0, at the next clock edge.
- R7: When a hardware set event and a clear (acknowledge or software write of 0) hit the same flag in the same cycle, the flag ends up set.
- R8: The run bits (bit 6 for timer 1, bit 4 for timer 0) drive `tmr_run[1]` and `tmr_run[0]`.
- R9: In edge mode (mode bit = 1), a falling edge on a pin sets that pin's flag 3 clock edges after the pin changes. A pin that is held low produces only one event, so once acknowledged the flag stays clear.
- R10: In level mode (mode bit = 0), the request equals the inverted pin 2 clock edges after the pin changes. Acknowledges and software writes of 0 have no effect on it while the pin stays low.
- R11: In edge mode, an external flag is cleared by its acknowledge strobe or by a software write of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Register or bit address |
| byte_wr | input | 1 | Byte write strobe |
| wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Bit write strobe |
| bit_wdata | input | 1 | Bit write value |
| rdata | output | 8 | Byte read data |
| bit_rdata | output | 1 | Bit read data |
| tmr_ovf | input | 2 | Overflow pulses from timers 1..0 |
| tmr_ack | input | 2 | Timer interrupt serviced strobes |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| ext_ack | input | 2 | External interrupt serviced strobes |
| tmr_run | output | 2 | Timer run enables |
| tmr_req | output | 2 | Timer overflow requests |
| ext_req | output | 2 | External interrupt requests |

## Verification
Write strobes and timer events take effect one clock edge after they are driven. A level-mode request follows a pin change after two edges, which is the synchronizer latency. An edge-mode flag appears after three edges, because it needs the synchronizer plus the latching register. The bench drives inputs on falling clock edges and samples one falling edge per expected register stage. It also checks the cycle just before a result is due, so that early arrival is caught as well as late arrival.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_TMR = 2;
  localparam int NUM_EXT = 2;

  typedef struct packed {
    logic [REG_W-1:0] en;
    logic [REG_W-1:0] val;
  } wr_req_t;

  // Bit placement: each source owns a flag/control pair, higher index higher.
  function automatic int tmr_flag_pos(input int i);
    return 5 + 2 * i;
  endfunction
  function automatic int tmr_run_pos(input int i);
    return 4 + 2 * i;
  endfunction
  function automatic int ext_flag_pos(input int i);
    return 1 + 2 * i;
  endfunction
  function automatic int ext_mode_pos(input int i);
    return 2 * i;
  endfunction

  // Per-bit write enables and values; byte access wins over bit access.
  function automatic wr_req_t decode_write(input logic byte_hit, input logic bit_hit,
                                           input logic [2:0] sel,
                                           input logic [REG_W-1:0] bval,
                                           input logic bv);
    wr_req_t r;
    r.en  = '0;
    r.val = '0;
    if (byte_hit) begin
      r.en  = '1;
      r.val = bval;
    end else if (bit_hit) begin
      r.en[sel]  = 1'b1;
      r.val[sel] = bv;
    end
    return r;
  endfunction
endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tic_flag.sv
module tic_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ack,
  input  logic we,
  input  logic wv,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (set_evt) q <= 1'b1;
    else if (ack)     q <= 1'b0;
    else if (we)      q <= wv;
  end

  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n) set_evt |=> q);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || (we && !wv)) && !set_evt |=> !q);
  p_hw_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt && (ack || (we && !wv)) |=> q);
endmodule

// File: rtl/tic_ext_chan.sv
module tic_ext_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic ack,
  input  logic we,
  input  logic wv,
  output logic req
);
  logic pin_s, prev_s, fall_evt, lat_q;

  tic_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_s <= 1'b1;
    else        prev_s <= pin_s;
  end

  assign fall_evt = prev_s & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat_q <= 1'b0;
    else if (!edge_mode) lat_q <= 1'b0;
    else if (fall_evt)  lat_q <= 1'b1;
    else if (ack)       lat_q <= 1'b0;
    else if (we)        lat_q <= wv;
  end

  assign req = edge_mode ? lat_q : ~pin_s;

  p_edge_once_r9: assert property (@(posedge clk) disable iff (!rst_n) fall_evt |=> !fall_evt);
  p_edge_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode && fall_evt |=> lat_q);
  p_edge_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode && !fall_evt && ack |=> !lat_q);
  p_level_no_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> !lat_q);
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
  import tic_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 'h88,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               byte_wr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               bit_wr,
  input  logic               bit_wdata,
  output logic [REG_W-1:0]   rdata,
  output logic               bit_rdata,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  input  logic [NUM_TMR-1:0] tmr_ack,
  input  logic [NUM_EXT-1:0] ext_pin_n,
  input  logic [NUM_EXT-1:0] ext_ack,
  output logic [NUM_TMR-1:0] tmr_run,
  output logic [NUM_TMR-1:0] tmr_req,
  output logic [NUM_EXT-1:0] ext_req
);
  logic [ADDR_W-1:0]  offset;
  logic               byte_hit, bit_hit;
  wr_req_t            wr;
  logic [NUM_TMR-1:0] run_q;
  logic [NUM_EXT-1:0] mode_q;
  logic [REG_W-1:0]   reg_view;

  assign offset   = addr - REG_ADDR;
  assign byte_hit = (addr == REG_ADDR);
  assign bit_hit  = (addr >= REG_ADDR) && (offset < ADDR_W'(REG_W));
  assign wr       = decode_write(byte_wr && byte_hit, bit_wr && bit_hit,
                                 offset[2:0], wdata, bit_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      mode_q <= '0;
    end else begin
      for (int i = 0; i < NUM_TMR; i++)
        if (wr.en[tmr_run_pos(i)]) run_q[i] <= wr.val[tmr_run_pos(i)];
      for (int i = 0; i < NUM_EXT; i++)
        if (wr.en[ext_mode_pos(i)]) mode_q[i] <= wr.val[ext_mode_pos(i)];
    end
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    tic_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_evt(tmr_ovf[t]), .ack(tmr_ack[t]),
      .we(wr.en[tmr_flag_pos(t)]), .wv(wr.val[tmr_flag_pos(t)]), .q(tmr_req[t])
    );
  end

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    tic_ext_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n[e]), .edge_mode(mode_q[e]),
      .ack(ext_ack[e]), .we(wr.en[ext_flag_pos(e)]), .wv(wr.val[ext_flag_pos(e)]),
      .req(ext_req[e])
    );
  end

  always_comb begin
    reg_view = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      reg_view[tmr_flag_pos(i)] = tmr_req[i];
      reg_view[tmr_run_pos(i)]  = run_q[i];
    end
    for (int i = 0; i < NUM_EXT; i++) begin
      reg_view[ext_flag_pos(i)] = ext_req[i];
      reg_view[ext_mode_pos(i)] = mode_q[i];
    end
  end

  assign rdata     = byte_hit ? reg_view : '0;
  assign bit_rdata = bit_hit ? reg_view[offset[2:0]] : 1'b0;
  assign tmr_run   = run_q;

  // A bit write aimed at a flag must leave every control bit untouched.
  p_bitwr_isolate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr && !byte_wr && (addr == REG_ADDR + ADDR_W'(7)) |=> $stable({run_q, mode_q}));
  p_foreign_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr && !byte_hit && !bit_wr |=> $stable({run_q, mode_q}));
endmodule

// File: tb/test_tmr_irq_ctl.sv
module test_tmr_irq_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       byte_wr = 1'b0, bit_wr = 1'b0, bit_wdata = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       bit_rdata;
  logic [1:0] tmr_ovf = '0, tmr_ack = '0, ext_pin_n = 2'b11, ext_ack = '0;
  logic [1:0] tmr_run, tmr_req, ext_req;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tmr_irq_ctl i_tmr_irq_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .byte_wr(byte_wr), .wdata(wdata),
    .bit_wr(bit_wr), .bit_wdata(bit_wdata), .rdata(rdata), .bit_rdata(bit_rdata),
    .tmr_ovf(tmr_ovf), .tmr_ack(tmr_ack), .ext_pin_n(ext_pin_n), .ext_ack(ext_ack),
    .tmr_run(tmr_run), .tmr_req(tmr_req), .ext_req(ext_req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] v);
    addr = a; wdata = v; byte_wr = 1'b1;
    tick(1);
    byte_wr = 1'b0;
  endtask

  task automatic wr_bit(input logic [7:0] a, input logic v);
    addr = a; bit_wdata = v; bit_wr = 1'b1;
    tick(1);
    bit_wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [7:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic rd_bit(input logic [7:0] a, output logic v);
    addr = a; #1; v = bit_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_byte(8'h88, v);
    chk("R1 reg", v, 8'h00);
    chk("R1 outs", {2'b0, tmr_run, tmr_req, ext_req}, 8'h00);
  endtask

  task automatic t_byte_access;
    logic [7:0] v;
    wr_byte(8'h88, 8'h55);
    rd_byte(8'h88, v);
    chk("R2 byte write", v, 8'h55);
    chk("R8 run out", {6'b0, tmr_run}, 8'h03);
    wr_byte(8'h89, 8'h00);
    rd_byte(8'h88, v);
    chk("R2 foreign byte write", v, 8'h55);
    wr_byte(8'h88, 8'h00);
  endtask

  task automatic t_bit_access;
    logic [7:0] v;
    logic b;
    wr_bit(8'h8E, 1'b1);
    rd_byte(8'h88, v);
    chk("R3 set bit6", v, 8'h40);
    chk("R8 run1 only", {6'b0, tmr_run}, 8'h02);
    wr_bit(8'h88, 1'b1);
    rd_byte(8'h88, v);
    chk("R3 set bit0", v, 8'h41);
    wr_bit(8'h8E, 1'b0);
    rd_byte(8'h88, v);
    chk("R3 clear bit6", v, 8'h01);
    rd_bit(8'h88, b);
    chk("R4 bit read 0x88", {7'b0, b}, 8'h01);
    rd_bit(8'h8E, b);
    chk("R4 bit read 0x8E", {7'b0, b}, 8'h00);
    rd_bit(8'h90, b);
    chk("R4 bit read out of range", {7'b0, b}, 8'h00);
    rd_byte(8'h89, v);
    chk("R4 byte read other addr", v, 8'h00);
    wr_byte(8'h88, 8'h00);
  endtask

  task automatic t_timer_flags;
    logic [7:0] v;
    tmr_ovf = 2'b01; tick(1); tmr_ovf = 2'b00;
    rd_byte(8'h88, v);
    chk("R5 tmr0 flag bit5", v, 8'h20);
    tick(3);
    chk("R5 tmr0 holds", {6'b0, tmr_req}, 8'h01);
    tmr_ack = 2'b01; tick(1); tmr_ack = 2'b00;
    chk("R6 ack clears tmr0", {6'b0, tmr_req}, 8'h00);
    tmr_ovf = 2'b10; tick(1); tmr_ovf = 2'b00;
    rd_byte(8'h88, v);
    chk("R5 tmr1 flag bit7", v, 8'h80);
    wr_bit(8'h8F, 1'b0);
    chk("R6 sw clears tmr1", {6'b0, tmr_req}, 8'h00);
  endtask

  task automatic t_priority;
    tmr_ovf = 2'b01; tmr_ack = 2'b01; tick(1); tmr_ovf = 2'b00; tmr_ack = 2'b00;
    chk("R7 ovf beats ack", {6'b0, tmr_req}, 8'h01);
    tmr_ovf = 2'b10; addr = 8'h8F; bit_wdata = 1'b0; bit_wr = 1'b1;
    tick(1);
    tmr_ovf = 2'b00; bit_wr = 1'b0;
    chk("R7 ovf beats sw clear", {6'b0, tmr_req}, 8'h03);
    tmr_ack = 2'b11; tick(1); tmr_ack = 2'b00;
    chk("R6 dual ack", {6'b0, tmr_req}, 8'h00);
  endtask

  task automatic t_edge_mode;
    logic [7:0] v;
    wr_byte(8'h88, 8'h01);
    ext_pin_n[0] = 1'b0;
    tick(2);
    chk("R9 not before 3 edges", {6'b0, ext_req}, 8'h00);
    tick(1);
    chk("R9 latched at 3 edges", {6'b0, ext_req}, 8'h01);
    rd_byte(8'h88, v);
    chk("R9 read bit1", v, 8'h03);
    ext_ack[0] = 1'b1; tick(1); ext_ack[0] = 1'b0;
    chk("R11 ack clears ext0", {6'b0, ext_req}, 8'h00);
    tick(5);
    chk("R9 held low single event", {6'b0, ext_req}, 8'h00);
    ext_pin_n[0] = 1'b1; tick(3);
    ext_pin_n[0] = 1'b0; tick(3);
    chk("R9 second edge", {6'b0, ext_req}, 8'h01);
    wr_bit(8'h89, 1'b0);
    chk("R11 sw clears ext0", {6'b0, ext_req}, 8'h00);
    ext_pin_n[0] = 1'b1; tick(3);
    wr_byte(8'h88, 8'h00);
  endtask

  task automatic t_level_mode;
    logic b;
    ext_pin_n[1] = 1'b0;
    tick(1);
    chk("R10 not before 2 edges", {6'b0, ext_req}, 8'h00);
    tick(1);
    chk("R10 request at 2 edges", {6'b0, ext_req}, 8'h02);
    rd_bit(8'h8B, b);
    chk("R10 bit read 0x8B", {7'b0, b}, 8'h01);
    ext_ack[1] = 1'b1; addr = 8'h8B; bit_wdata = 1'b0; bit_wr = 1'b1;
    tick(1);
    ext_ack[1] = 1'b0; bit_wr = 1'b0;
    chk("R10 clear ignored while low", {6'b0, ext_req}, 8'h02);
    ext_pin_n[1] = 1'b1;
    tick(1);
    chk("R10 still up 1 edge after release", {6'b0, ext_req}, 8'h02);
    tick(1);
    chk("R10 drops 2 edges after release", {6'b0, ext_req}, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog all-R actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_byte_access();
    t_bit_access();
    t_timer_flags();
    t_priority();
    t_edge_mode();
    t_level_mode();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule